// File: doc/BRIEF.md
# Static Branch Direction Predictor with Compiler Hints

This block sits beside the fetch stage and makes a guess for every conditional branch as it is fetched. With no hint present, the guess comes from which way the branch jumps. A branch that jumps to a lower or equal address usually closes a loop, so it is guessed taken. A branch that jumps to a higher address is guessed not taken. When the compiler supplies a valid hint, the hint's direction replaces that guess. The guess and the predicted next fetch address appear combinationally in the same cycle as the fetch.

Every accepted guess is kept in a small in-order queue, together with the branch address and its target. When the pipeline resolves the oldest branch, the block compares the real outcome with the stored guess. If they differ, the cycle after the resolution it raises a one-cycle restart request carrying the correct address.

Three saturating counters record how many branches resolved, how many were taken and how many were mispredicted. A flush drops all outstanding guesses and leaves the counters alone.

Queue occupancy is an enumerated state machine with three states:
- `Q_EMPTY`: no outstanding guesses.
- `Q_PART`: one to DEPTH-1 outstanding guesses.
- `Q_FULL`: DEPTH outstanding guesses.

Its transitions are:
- fill: `Q_EMPTY` to `Q_PART` on an accepted fetch.
- top-up: `Q_PART` to `Q_FULL` when the last free slot is taken.
- drain: `Q_FULL` to `Q_PART` on a resolution.
- retire: `Q_PART` to `Q_EMPTY` when the last guess resolves.
- purge: any state to `Q_EMPTY` on flush.
- idle: the state holds when nothing changes the occupancy.

Top module: `brpred_static`

## Requirements
- R1: With no valid hint, a branch whose target is lower than its own address is predicted taken, and pred_next_pc equals the target, in the same cycle.
- R2: With no valid hint, a branch whose target equals its own address is predicted taken, with pred_next_pc equal to the target.
- R3: With no valid hint, a branch whose target is higher than its own address is predicted not taken, and pred_next_pc is the branch address plus one, modulo 2^PC_W.
- R4: When hint_valid is 1, pred_taken equals hint_taken whatever the branch direction, and pred_next_pc follows that choice.
- R5: When a resolution's outcome differs from the guess stored for the oldest outstanding branch, mispredict is 1 for exactly the next cycle. In that cycle redirect_pc is the target if the branch was taken, or the branch address plus one (modulo 2^PC_W) if it was not. A resolution that agrees with the guess leaves mispredict at 0.
- R6: Up to DEPTH (default 4) guesses are held and resolved in fetch order. slots_full is 1 while DEPTH are outstanding. A fetch seen while slots_full is 1 is dropped, even if a resolution arrives in the same cycle.
- R7: A resolution that arrives while no guess is outstanding is ignored: mispredict stays 0 and no counter changes.
- R8: Flush empties the queue in one cycle and leaves the counters unchanged. A fetch or resolution in the same cycle as a flush is ignored and raises no mispredict.
- R9: On each accepted resolution, stat_total increments by one, stat_taken increments if the outcome was taken, and stat_mispred increments on a mispredict. Each counter saturates at all ones (65535 by default).
- R10: After reset the counters are zero, the queue is empty, slots_full is 0 and mispredict is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A conditional branch is being fetched |
| fetch_pc | input | PC_W | Address of the fetched branch |
| fetch_target | input | PC_W | Target address of the fetched branch |
| hint_valid | input | 1 | Compiler hint accompanies the branch |
| hint_taken | input | 1 | Hinted direction (1 = taken) |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| slots_full | output | 1 | All DEPTH queue slots are occupied |
| resolve_valid | input | 1 | The oldest branch has resolved |
| resolve_taken | input | 1 | Actual outcome (1 = taken) |
| flush | input | 1 | Discard all outstanding guesses |
| mispredict | output | 1 | Restart request, one cycle |
| redirect_pc | output | PC_W | Correct restart address |
| stat_total | output | CNT_W | Resolved branch count |
| stat_taken | output | CNT_W | Taken branch count |
| stat_mispred | output | CNT_W | Mispredict count |

## Verification
Two functions can fall in the same cycle: pushing a new guess at fetch, and popping the oldest guess at resolution. The bench drives both together in three situations:
- with a partly filled queue, where both must take effect;
- with a full queue, where the push must be dropped while the pop proceeds;
- against a simultaneous flush, which must cancel both.

A behavioural queue model in the bench predicts occupancy, mispredict, redirect address and counters every cycle, and the DUT's outputs are compared with it at each falling edge.

// File: rtl/brp_pkg.sv
package brp_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/brp_dir.sv
module brp_dir #(
    parameter int unsigned PC_W = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    input  logic            hint_valid,
    input  logic            hint_taken,
    output logic            taken,
    output logic [PC_W-1:0] next_pc
);
    logic backward;

    always_comb begin
        backward = (target <= pc);
        taken    = hint_valid ? hint_taken : backward;
        next_pc  = taken ? target : pc + PC_W'(1);
    end
endmodule

// File: rtl/brp_queue.sv
module brp_queue
    import brp_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    occ_state_t        state, state_nxt;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count, count_nxt;
    logic              empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // output decode from the occupancy state
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            Q_EMPTY: empty = 1'b1;
            Q_PART:  ;
            Q_FULL:  full = 1'b1;
            default: empty = 1'b1;
        endcase
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        head    = mem[rd_ptr];
    end

    // next-state: fill, top-up, drain, retire, purge, idle
    always_comb begin
        count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (flush)
            count_nxt = '0;
        if (count_nxt == '0)
            state_nxt = Q_EMPTY;
        else if (count_nxt == CNT_W'(DEPTH))
            state_nxt = Q_FULL;
        else
            state_nxt = Q_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= Q_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop_ok)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wdata;
    end

    // R6
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == Q_EMPTY));
    // R6
    full_state_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) |-> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/brp_stats.sv
module brp_stats #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_ok,
    input  logic             was_taken,
    input  logic             was_wrong,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] taken,
    output logic [CNT_W-1:0] wrong
);
    localparam int unsigned NCTR = 3;

    logic [NCTR-1:0]       inc;
    logic [NCTR*CNT_W-1:0] flat;

    assign inc = {event_ok && was_wrong, event_ok && was_taken, event_ok};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        logic [CNT_W-1:0] c;
        always_ff @(posedge clk) begin
            if (!rst_n)
                c <= '0;
            else if (inc[g] && (c != '1))
                c <= c + CNT_W'(1);
        end
        assign flat[g*CNT_W +: CNT_W] = c;
    end

    assign total = flat[0 +: CNT_W];
    assign taken = flat[CNT_W +: CNT_W];
    assign wrong = flat[2*CNT_W +: CNT_W];

    // R9
    total_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (total >= $past(total)));
    // R9
    taken_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken <= total);
    // R9
    wrong_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrong <= total);
endmodule

// File: rtl/brpred_static.sv
module brpred_static #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [PC_W-1:0]  fetch_target,
    input  logic             hint_valid,
    input  logic             hint_taken,
    output logic             pred_taken,
    output logic [PC_W-1:0]  pred_next_pc,
    output logic             slots_full,
    input  logic             resolve_valid,
    input  logic             resolve_taken,
    input  logic             flush,
    output logic             mispredict,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [CNT_W-1:0] stat_total,
    output logic [CNT_W-1:0] stat_taken,
    output logic [CNT_W-1:0] stat_mispred
);
    localparam int unsigned ENT_W = 2 * PC_W + 1;

    logic [ENT_W-1:0] head_ent;
    logic             push_ok, pop_ok;
    logic [PC_W-1:0]  head_pc, head_tgt;
    logic             head_pred, wrong_now;
    logic [PC_W-1:0]  fix_pc;

    brp_dir #(.PC_W(PC_W)) dir_u (
        .pc         (fetch_pc),
        .target     (fetch_target),
        .hint_valid (hint_valid),
        .hint_taken (hint_taken),
        .taken      (pred_taken),
        .next_pc    (pred_next_pc)
    );

    brp_queue #(.DEPTH(DEPTH), .DATA_W(ENT_W)) queue_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fetch_valid),
        .pop     (resolve_valid),
        .flush   (flush),
        .wdata   ({pred_taken, fetch_target, fetch_pc}),
        .head    (head_ent),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .full    (slots_full)
    );

    always_comb begin
        head_pc   = head_ent[PC_W-1:0];
        head_tgt  = head_ent[2*PC_W-1:PC_W];
        head_pred = head_ent[ENT_W-1];
        wrong_now = pop_ok && (resolve_taken != head_pred);
        fix_pc    = resolve_taken ? head_tgt : head_pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mispredict  <= 1'b0;
            redirect_pc <= '0;
        end else begin
            mispredict <= wrong_now;
            if (wrong_now)
                redirect_pc <= fix_pc;
        end
    end

    brp_stats #(.CNT_W(CNT_W)) stats_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_ok  (pop_ok),
        .was_taken (resolve_taken),
        .was_wrong (wrong_now),
        .total     (stat_total),
        .taken     (stat_taken),
        .wrong     (stat_mispred)
    );

    // R5
    redirect_follows_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> $past(resolve_valid));
    // R1
    taken_next_is_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (pred_next_pc == fetch_target));
    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !mispredict);
    // R9
    mispredict_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict && ($past(stat_mispred) != '1)) |-> (stat_mispred != $past(stat_mispred)));
endmodule

// File: tb/brpred_static_tb.sv
module brpred_static_tb_top;
    localparam int CLK_P = 10;
    localparam int PW    = 16;
    localparam int MAXC  = 65535;

    logic clk = 0, rst_n = 0;
    logic fetch_valid = 0, hint_valid = 0, hint_taken = 0;
    logic [PW-1:0] fetch_pc = 0, fetch_target = 0;
    logic resolve_valid = 0, resolve_taken = 0, flush = 0;
    logic pred_taken, slots_full, mispredict;
    logic [PW-1:0] pred_next_pc, redirect_pc;
    logic [15:0] stat_total, stat_taken, stat_mispred;

    always #(CLK_P/2) clk = ~clk;

    brpred_static dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_target(fetch_target), .hint_valid(hint_valid), .hint_taken(hint_taken),
        .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .slots_full(slots_full),
        .resolve_valid(resolve_valid), .resolve_taken(resolve_taken), .flush(flush),
        .mispredict(mispredict), .redirect_pc(redirect_pc), .stat_total(stat_total),
        .stat_taken(stat_taken), .stat_mispred(stat_mispred)
    );

    typedef struct { int pc; int tg; bit pt; } ent_t;
    ent_t q[$];
    int n_chk = 0, n_fail = 0;
    int m_total = 0, m_taken = 0, m_wrong = 0, m_redir = 0;
    bit m_mp = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    task automatic check_regs(string tag);
        chk({tag, " R5 mispredict"}, int'(mispredict), int'(m_mp));
        if (m_mp) chk({tag, " R5 redirect_pc"}, int'(redirect_pc), m_redir);
        chk({tag, " R9 stat_total"}, int'(stat_total), m_total);
        chk({tag, " R9 stat_taken"}, int'(stat_taken), m_taken);
        chk({tag, " R9 stat_mispred"}, int'(stat_mispred), m_wrong);
        chk({tag, " R6 slots_full"}, int'(slots_full), int'(q.size() == 4));
    endtask

    // drive one cycle at the falling edge, check prediction, clock, update model, check registers
    task automatic cyc(string tag, bit fv, int pc, int tg, bit hv, bit ht, bit rv, bit rt, bit fl);
        bit pt, full_before;
        int nx;
        ent_t e;
        fetch_valid = fv; fetch_pc = PW'(pc); fetch_target = PW'(tg);
        hint_valid = hv; hint_taken = ht;
        resolve_valid = rv; resolve_taken = rt; flush = fl;
        pt = hv ? ht : (tg <= pc);
        nx = pt ? tg : ((pc + 1) & 16'hFFFF);
        #1;
        chk({tag, " R1/R2/R3/R4 pred_taken"}, int'(pred_taken), int'(pt));
        chk({tag, " R1/R2/R3/R4 pred_next_pc"}, int'(pred_next_pc), nx);
        @(posedge clk);
        full_before = (q.size() == 4);
        m_mp = 0;
        if (fl) begin
            q.delete();
        end else begin
            if (rv && q.size() > 0) begin
                e = q.pop_front();
                m_total = sat(m_total);
                if (rt) m_taken = sat(m_taken);
                if (rt != e.pt) begin
                    m_mp = 1;
                    m_wrong = sat(m_wrong);
                    m_redir = rt ? e.tg : ((e.pc + 1) & 16'hFFFF);
                end
            end
            if (fv && !full_before) q.push_back('{pc, tg, pt});
        end
        @(negedge clk);
        check_regs(tag);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_regs("reset R10");

        // R1 backward, R2 equal, R3 forward, R4 hints
        cyc("R1 backward", 1, 16'h0100, 16'h0080, 0, 0, 0, 0, 0);
        cyc("R2 equal", 1, 16'h0200, 16'h0200, 0, 0, 0, 0, 0);
        cyc("R3 forward", 1, 16'hFFFE, 16'hFFFF, 0, 0, 0, 0, 0);
        cyc("R4 hint taken fwd", 1, 16'h0300, 16'h0400, 1, 1, 0, 0, 0);
        // queue now full: fifth fetch dropped R6
        cyc("R6 drop when full", 1, 16'h0500, 16'h0010, 0, 0, 0, 0, 0);
        // R6 full with simultaneous resolve: push dropped, pop proceeds; R5 backward predicted taken, actually not
        cyc("R6 full push+pop", 1, 16'h0600, 16'h0601, 0, 0, 1, 0, 0);
        cyc("R5 equal agrees", 0, 0, 0, 0, 0, 1, 1, 0);
        cyc("R5 forward actually taken", 0, 0, 0, 0, 0, 1, 1, 0);
        cyc("R5 hint agrees", 0, 0, 0, 0, 0, 1, 1, 0);
        // R7 resolve on empty queue ignored
        cyc("R7 resolve empty", 0, 0, 0, 0, 0, 1, 0, 0);
        // R4 hint not taken on backward, then R5 wrap to 0
        cyc("R4 hint nt bwd", 1, 16'hFFFF, 16'h0001, 1, 0, 0, 0, 0);
        cyc("R5 taken vs nt hint", 1, 16'hFFFF, 16'h0002, 0, 0, 1, 1, 0);
        cyc("R5 pc wrap", 0, 0, 0, 0, 0, 1, 0, 0);
        // R6 same-cycle push and pop with a partial queue
        cyc("R6 push1", 1, 16'h0700, 16'h0750, 0, 0, 0, 0, 0);
        cyc("R6 push+pop", 1, 16'h0800, 16'h0010, 0, 0, 1, 1, 0);
        // R8 flush with simultaneous fetch and resolve
        cyc("R8 flush", 1, 16'h0900, 16'h0001, 0, 0, 1, 0, 1);
        cyc("R8 after flush", 0, 0, 0, 0, 0, 1, 1, 0);
        // R9 saturation: one outstanding backward guess, then fetch+resolve every cycle
        cyc("R9 seed", 1, 16'h1000, 16'h0F00, 0, 0, 0, 0, 0);
        for (int i = 0; i < 66000; i++)
            cyc("R9 saturate", 1, 16'h1000, 16'h0F00, 0, 0, 1, 1, 0);
        chk("R9 total saturated", int'(stat_total), MAXC);
        cyc("R9 hold after sat", 0, 0, 0, 0, 0, 1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule